// File: doc/BRIEF.md
# Endpoint-Zero Control and Status Register

This block holds the status and command bits of a control endpoint (endpoint zero) on the device side of a USB-style link. A processor writes and reads it through an 8-bit data port with separate write and read strobes. The endpoint's packet engine feeds it events: packet received, packet sent, stall handshake sent, control transfer ended early, and status stage complete.

The bits come in two kinds. Event flags are set by the hardware and are cleared only by software, either through a write-one strobe bit in the same register or, for the stall flag, by writing zero. Command bits are set by software and clear themselves when the engine reports that the action is complete. The block drives a gated one-cycle interrupt pulse, a one-cycle FIFO flush pulse, a stall request to the engine, and the data-end flag.

Whenever a hardware set and a software clear reach the same bit in the same cycle, the bit ends up set. This means no event is lost to a write that was already in flight.

Top module: `ep0_ctrl_status`

## Requirements
- R1: After reset, every register bit, `irq`, `fifo_flush`, `stall_req` and `data_end` is 0.
- R2: A read shows send-stall at bit 5, setup-end at bit 4, data-end at bit 3, sent-stall at bit 2, tx-ready at bit 1 and rx-ready at bit 0. Bits 7 and 6 always read 0, and `rd_data` is 0 whenever `rd_en` is low.
- R3: `ev_rx_done` sets rx-ready (bit 0). A write with bit 6 = 1 clears it. If that write and `ev_rx_done` occur in the same cycle, the bit stays set.
- R4: A write with bit 1 = 1 sets tx-ready. `ev_tx_done` clears it. If the write and `ev_tx_done` occur in the same cycle, the bit stays set.
- R5: A write with bit 5 = 1 sets send-stall and raises `stall_req` in the next cycle. `ev_stall_sent` clears send-stall.
- R6: `ev_stall_sent` sets sent-stall (bit 2). A write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged. If a clearing write and `ev_stall_sent` occur in the same cycle, the bit stays set.
- R7: A write with bit 3 = 1 sets data-end and the `data_end` output. A write with bit 3 = 0 has no effect on it. `ev_status_done` clears it.
- R8: `ev_setup_end` arriving while data-end is 0 sets setup-end (bit 4) and gives a one-cycle `fifo_flush` pulse in the following cycle. While data-end is 1, the event changes nothing and gives no flush.
- R9: A write with bit 7 = 1 clears setup-end. If that write and a setting `ev_setup_end` occur in the same cycle, the bit stays set.
- R10: `irq` is a one-cycle pulse in the cycle after any of these: `ev_rx_done`; `ev_tx_done` while tx-ready is set; a setup-end set. It is raised only if `irq_en` was high in the event cycle.
- R11: Written values of bits 4 and 0 have no effect, and the register follows R3 to R9 for every one of the 256 write values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Read data, 0 when not reading |
| ev_rx_done | input | 1 | Engine: packet received |
| ev_tx_done | input | 1 | Engine: packet transmitted |
| ev_stall_sent | input | 1 | Engine: stall handshake transmitted |
| ev_setup_end | input | 1 | Engine: control transfer ended early |
| ev_status_done | input | 1 | Engine: status stage complete |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | One-cycle interrupt pulse |
| fifo_flush | output | 1 | One-cycle endpoint FIFO flush pulse |
| stall_req | output | 1 | Stall request to the engine |
| data_end | output | 1 | Data-end flag to the engine |

## Verification
Any wrong flag state is visible on the very next read. A lost or stuck flag also shows up one cycle after the event, as a missing or extra `irq` or `fifo_flush` pulse, or as a wrong level on `stall_req` or `data_end`.

The most likely faults are an inverted set/clear priority and a strobe bit wired to the wrong flag. Both show up in a single cycle, when an event is applied together with a write. They are exposed by a sweep that applies every write value after a burst of engine events.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
    localparam int DATA_W      = 8;
    localparam int NUM_FLAGS   = 6;
    localparam int NUM_IRQ_SRC = 3;

    // flag index equals its read-back bit position
    localparam int F_RX_RDY     = 0;
    localparam int F_TX_RDY     = 1;
    localparam int F_SENT_STALL = 2;
    localparam int F_DATA_END   = 3;
    localparam int F_SETUP_END  = 4;
    localparam int F_SEND_STALL = 5;

    // write bit positions of the two service strobes
    localparam int W_SVC_RX    = 6;
    localparam int W_SVC_SETUP = 7;

    // register bits that a written 1 sets directly
    localparam logic [NUM_FLAGS-1:0] SW_SET_MASK = 6'b101010;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] set;
        logic [NUM_FLAGS-1:0] clr;
    } flag_ctl_t;

    typedef struct packed {
        logic irq;
        logic flush;
    } pulse_t;
endpackage

// File: rtl/ep0_flag_cell.sv
module ep0_flag_cell #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_d, q_q;

    // set dominates clear
    always_comb begin
        q_d = set_i | (q_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= RESET_VAL;
        else        q_q <= q_d;
    end

    assign q_o = q_q;
endmodule

// File: rtl/ep0_pulse_gen.sv
module ep0_pulse_gen
    import ep0_csr_pkg::*;
#(
    parameter int SRC_W = NUM_IRQ_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_en,
    input  logic [SRC_W-1:0] irq_src,
    input  logic             flush_src,
    output logic             irq,
    output logic             fifo_flush
);
    pulse_t p_d, p_q;

    always_comb begin
        p_d.irq   = irq_en & (|irq_src);
        p_d.flush = flush_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign irq        = p_q.irq;
    assign fifo_flush = p_q.flush;
endmodule

// File: rtl/ep0_ctrl_status.sv
module ep0_ctrl_status
    import ep0_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_rx_done,
    input  logic              ev_tx_done,
    input  logic              ev_stall_sent,
    input  logic              ev_setup_end,
    input  logic              ev_status_done,
    input  logic              irq_en,
    output logic              irq,
    output logic              fifo_flush,
    output logic              stall_req,
    output logic              data_end
);
    localparam int PAD_W = DATA_W - NUM_FLAGS;

    logic [NUM_FLAGS-1:0]   flag_q;
    logic [DATA_W-1:0]      wr_one;
    logic                   wr_zero_stall;
    flag_ctl_t              ctl_d;
    logic [NUM_IRQ_SRC-1:0] irq_src;
    logic                   setup_hit;

    always_comb begin
        wr_one        = {DATA_W{wr_en}} & wr_data;
        wr_zero_stall = wr_en & ~wr_data[F_SENT_STALL];
        setup_hit     = ev_setup_end & ~flag_q[F_DATA_END];

        ctl_d.set = wr_one[NUM_FLAGS-1:0] & SW_SET_MASK;
        ctl_d.set[F_RX_RDY]     = ev_rx_done;
        ctl_d.set[F_SENT_STALL] = ev_stall_sent;
        ctl_d.set[F_SETUP_END]  = setup_hit;

        ctl_d.clr = '0;
        ctl_d.clr[F_RX_RDY]     = wr_one[W_SVC_RX];
        ctl_d.clr[F_TX_RDY]     = ev_tx_done;
        ctl_d.clr[F_SENT_STALL] = wr_zero_stall;
        ctl_d.clr[F_DATA_END]   = ev_status_done;
        ctl_d.clr[F_SETUP_END]  = wr_one[W_SVC_SETUP];
        ctl_d.clr[F_SEND_STALL] = ev_stall_sent;

        irq_src = {setup_hit, ev_tx_done & flag_q[F_TX_RDY], ev_rx_done};
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        ep0_flag_cell #(.RESET_VAL(1'b0)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (ctl_d.set[i]),
            .clr_i (ctl_d.clr[i]),
            .q_o   (flag_q[i])
        );
    end

    ep0_pulse_gen #(.SRC_W(NUM_IRQ_SRC)) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_en     (irq_en),
        .irq_src    (irq_src),
        .flush_src  (setup_hit),
        .irq        (irq),
        .fifo_flush (fifo_flush)
    );

    assign rd_data   = rd_en ? {{PAD_W{1'b0}}, flag_q} : '0;
    assign stall_req = flag_q[F_SEND_STALL];
    assign data_end  = flag_q[F_DATA_END];
endmodule

// File: rtl/ep0_ctrl_status_checker.sv
module ep0_ctrl_status_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       ev_rx_done,
    input logic       ev_tx_done,
    input logic       ev_stall_sent,
    input logic       ev_setup_end,
    input logic       ev_status_done,
    input logic       irq_en,
    input logic       irq,
    input logic       fifo_flush,
    input logic       stall_req,
    input logic       data_end,
    input logic [5:0] flag_q
);
    p_rx_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_done |=> flag_q[0]);
    p_rx_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[6] && !ev_rx_done) |=> !flag_q[0]);
    p_tx_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_done && !(wr_en && wr_data[1])) |=> !flag_q[1]);
    p_stall_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[5]) |=> stall_req);
    p_sent_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stall_sent |=> flag_q[2]);
    p_data_end_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_status_done && !(wr_en && wr_data[3])) |=> !data_end);
    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_setup_end && !data_end) |=> (fifo_flush && flag_q[4]));
    p_flush_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> flag_q[4]);
    p_setup_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_setup_end && !flag_q[4]) |=> !flag_q[4]);
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);
endmodule

bind ep0_ctrl_status ep0_ctrl_status_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .ev_rx_done     (ev_rx_done),
    .ev_tx_done     (ev_tx_done),
    .ev_stall_sent  (ev_stall_sent),
    .ev_setup_end   (ev_setup_end),
    .ev_status_done (ev_status_done),
    .irq_en         (irq_en),
    .irq            (irq),
    .fifo_flush     (fifo_flush),
    .stall_req      (stall_req),
    .data_end       (data_end),
    .flag_q         (flag_q)
);

// File: tb/ep0_ctrl_status_test.sv
module ep0_ctrl_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       ev_rx_done = 1'b0, ev_tx_done = 1'b0, ev_stall_sent = 1'b0;
    logic       ev_setup_end = 1'b0, ev_status_done = 1'b0;
    logic       irq_en = 1'b1;
    logic       irq, fifo_flush, stall_req, data_end;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // event vector order: {setup_end, status_done, stall_sent, tx_done, rx_done}
    localparam logic [4:0] EV_NONE = 5'b00000;
    localparam logic [4:0] EV_RX   = 5'b00001;
    localparam logic [4:0] EV_TX   = 5'b00010;
    localparam logic [4:0] EV_SS   = 5'b00100;
    localparam logic [4:0] EV_ST   = 5'b01000;
    localparam logic [4:0] EV_SE   = 5'b10000;

    always #4 clk = ~clk;

    ep0_ctrl_status uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done),
        .ev_stall_sent(ev_stall_sent), .ev_setup_end(ev_setup_end),
        .ev_status_done(ev_status_done), .irq_en(irq_en),
        .irq(irq), .fifo_flush(fifo_flush), .stall_req(stall_req),
        .data_end(data_end)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // one clock: drive at a falling edge, result visible at the next one
    task automatic cyc(input logic w, input logic [7:0] wv, input logic [4:0] ev);
        wr_en = w;
        wr_data = wv;
        {ev_setup_end, ev_status_done, ev_stall_sent, ev_tx_done, ev_rx_done} = ev;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        {ev_setup_end, ev_status_done, ev_stall_sent, ev_tx_done, ev_rx_done} = EV_NONE;
    endtask

    task automatic rd(output logic [7:0] v);
        rd_en = 1'b1;
        #1;
        v = rd_data;
        rd_en = 1'b0;
        #1;
    endtask

    task automatic chk_reg(input logic [7:0] exp, input string tag);
        logic [7:0] v;
        rd(v);
        check(v, exp, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual 00 expected 01");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] m;
        logic       m3old;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_reg(8'h00, "R1 reg");
        check({7'b0, irq}, 8'h00, "R1 irq");
        check({7'b0, fifo_flush}, 8'h00, "R1 flush");
        check({7'b0, stall_req}, 8'h00, "R1 stall_req");
        check({7'b0, data_end}, 8'h00, "R1 data_end");

        // R3 rx-ready and R10 interrupt
        cyc(1'b0, 8'h00, EV_RX);
        check(rd_data, 8'h00, "R2 rd_en low");
        check({7'b0, irq}, 8'h01, "R10 irq on rx");
        chk_reg(8'h01, "R3 rx set");
        cyc(1'b0, 8'h00, EV_NONE);
        check({7'b0, irq}, 8'h00, "R10 single pulse");
        cyc(1'b1, 8'h40, EV_NONE);
        chk_reg(8'h00, "R3 rx cleared");
        cyc(1'b1, 8'h40, EV_RX);
        chk_reg(8'h01, "R3 set wins");
        cyc(1'b1, 8'h40, EV_NONE);

        // R4 tx-ready
        cyc(1'b1, 8'h02, EV_NONE);
        chk_reg(8'h02, "R4 tx set");
        check({7'b0, irq}, 8'h00, "R10 no irq on write");
        cyc(1'b0, 8'h00, EV_TX);
        chk_reg(8'h00, "R4 tx cleared");
        check({7'b0, irq}, 8'h01, "R10 irq on tx done");
        cyc(1'b0, 8'h00, EV_TX);
        check({7'b0, irq}, 8'h00, "R10 no irq when tx idle");
        cyc(1'b1, 8'h02, EV_TX);
        chk_reg(8'h02, "R4 set wins");
        cyc(1'b0, 8'h00, EV_TX);

        // R5 send-stall, R6 sent-stall
        cyc(1'b1, 8'h20, EV_NONE);
        chk_reg(8'h20, "R5 send-stall set");
        check({7'b0, stall_req}, 8'h01, "R5 stall_req high");
        cyc(1'b0, 8'h00, EV_SS);
        chk_reg(8'h04, "R6 stall sent");
        check({7'b0, stall_req}, 8'h00, "R5 stall_req cleared");
        cyc(1'b1, 8'h04, EV_NONE);
        chk_reg(8'h04, "R6 write one keeps");
        cyc(1'b1, 8'h00, EV_NONE);
        chk_reg(8'h00, "R6 write zero clears");
        cyc(1'b1, 8'h00, EV_SS);
        chk_reg(8'h04, "R6 set wins");
        cyc(1'b1, 8'h00, EV_NONE);

        // R7 data-end, R8 blocked setup-end
        cyc(1'b1, 8'h08, EV_NONE);
        chk_reg(8'h08, "R7 data-end set");
        check({7'b0, data_end}, 8'h01, "R7 data_end out");
        cyc(1'b1, 8'h00, EV_NONE);
        chk_reg(8'h08, "R7 write zero ignored");
        cyc(1'b0, 8'h00, EV_SE);
        check({7'b0, fifo_flush}, 8'h00, "R8 no flush with data-end");
        check({7'b0, irq}, 8'h00, "R10 no irq blocked setup-end");
        chk_reg(8'h08, "R8 setup-end blocked");
        cyc(1'b0, 8'h00, EV_ST);
        chk_reg(8'h00, "R7 cleared by status");
        check({7'b0, data_end}, 8'h00, "R7 data_end low");

        // R8 setup-end, R9 service
        cyc(1'b0, 8'h00, EV_SE);
        check({7'b0, fifo_flush}, 8'h01, "R8 flush pulse");
        check({7'b0, irq}, 8'h01, "R10 irq on setup-end");
        chk_reg(8'h10, "R8 setup-end set");
        cyc(1'b0, 8'h00, EV_NONE);
        check({7'b0, fifo_flush}, 8'h00, "R8 flush single");
        cyc(1'b1, 8'h80, EV_NONE);
        chk_reg(8'h00, "R9 setup-end cleared");
        cyc(1'b1, 8'h80, EV_SE);
        chk_reg(8'h10, "R9 set wins");
        check({7'b0, fifo_flush}, 8'h01, "R9 flush with set");
        cyc(1'b1, 8'h80, EV_NONE);

        // R10 gated
        irq_en = 1'b0;
        cyc(1'b0, 8'h00, EV_RX);
        irq_en = 1'b1;
        check({7'b0, irq}, 8'h00, "R10 gated off");
        chk_reg(8'h01, "R3 set while gated");
        cyc(1'b1, 8'h40, EV_NONE);

        // R11 bits 4 and 0 ignored
        cyc(1'b1, 8'h11, EV_NONE);
        chk_reg(8'h00, "R11 write ones ignored");
        cyc(1'b0, 8'h00, EV_RX);
        cyc(1'b1, 8'h01, EV_NONE);
        chk_reg(8'h01, "R11 no clear by bit0");
        cyc(1'b1, 8'h40, EV_NONE);

        // sweep all write values after a burst of every event
        m = '0;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] wv;
            wv = 8'(v);
            m3old = m[3];
            irq_en = wv[0];
            cyc(1'b0, 8'h00, 5'b11111);
            irq_en = 1'b1;
            check({7'b0, irq}, {7'b0, wv[0]}, "R10 sweep irq");
            check({7'b0, fifo_flush}, {7'b0, ~m3old}, "R8 sweep flush");
            m[0] = 1'b1; m[1] = 1'b0; m[2] = 1'b1;
            m[3] = 1'b0; m[4] = m[4] | ~m3old; m[5] = 1'b0;
            chk_reg({2'b00, m}, "R11 sweep events");
            cyc(1'b1, wv, EV_NONE);
            m[0] = m[0] & ~wv[6];
            m[1] = m[1] | wv[1];
            m[2] = m[2] & wv[2];
            m[3] = m[3] | wv[3];
            m[4] = m[4] & ~wv[7];
            m[5] = m[5] | wv[5];
            chk_reg({2'b00, m}, "R11 sweep write");
            check({7'b0, data_end}, {7'b0, m[3]}, "R7 sweep data_end");
            check({7'b0, stall_req}, {7'b0, m[5]}, "R5 sweep stall_req");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule